// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This block watches thirteen general-purpose input pins, split into a low group of eight pins and a high group of five. Each pin has its own mask bit. A rising or falling level change on any unmasked pin sets a single sticky flag that belongs to the pin's group. Each group also has an enable bit. Each group drives one interrupt request line. The line is high while the group's flag and enable bit are set and the chip-wide interrupt-enable input is high.

Pins are asynchronous to the block clock. Each pin passes through a two-flop synchronizer before change detection. Software reaches four byte-wide registers through a simple single-cycle write port and a combinational read port. Unimplemented bits read as zero and ignore writes. A flag is cleared in one of two ways: software writes a one to the flag's bit, or the interrupt controller pulses a per-group service acknowledge. The block does not dispatch vectors.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, all four registers read 0x00 and both interrupt request lines are low.
- R2: The register address map is as follows. 0 is the control register, with bit 0 enabling group 0 and bit 1 enabling group 1. 1 is the flag register, with bit 0 holding the group 0 flag and bit 1 the group 1 flag. 2 is the group 0 mask, where bit i masks pin i. 3 is the group 1 mask, where bit i masks pin 8+i. Bits 7..2 of addresses 0 and 1, and bits 7..5 of address 3, always read zero and ignore writes.
- R3: A rising or a falling change on a pin whose mask bit is one sets that group's flag. The flag reads one on the third rising clock edge after the pin changes.
- R4: A change on a pin whose mask bit is zero leaves the flags unchanged. A change in one group never sets the other group's flag.
- R5: Writing the flag register clears each flag whose written bit is one. Flags whose written bit is zero are unchanged.
- R6: A one on ack_i[g] for one cycle clears flag g and no other flag.
- R7: When a detected change and a clear (by write or by acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R8: irq_o[g] is high exactly when flag g, enable bit g and glob_ie_i are all one.
- R9: Setting a mask bit while its pin is steady does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 13 | Watched pins; 7..0 group 0, 12..8 group 1 |
| glob_ie_i | input | 1 | Chip-wide interrupt enable |
| ack_i | input | 2 | Per-group service acknowledge, clears the flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_o | output | 2 | Interrupt request per group |

## Verification
A stale change-detect register would show up as a flag that sets without a pin change, for example just after a mask bit is set. A missing update would show up as a flag that never sets. Either error appears on the flag readback three edges after the pin moves. A wrong priority between setting and clearing would show up as a flag that reads zero right after a clear collides with a change, and the error would be visible on the very next cycle. A fault in the request gating appears on irq_o immediately, because irq_o has no register stage after the flag.

// File: rtl/pcx_pkg.sv
`timescale 1ns/1ps
package pcx_pkg;
   localparam int unsigned NUM_GRP = 2;
   localparam int unsigned ADDR_W  = 2;
   localparam logic [ADDR_W-1:0] RA_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] RA_FLAG  = 2'd1;
   localparam logic [ADDR_W-1:0] RA_MASK0 = 2'd2;
   localparam logic [ADDR_W-1:0] RA_MASK1 = 2'd3;
endpackage

// File: rtl/pcx_sync.sv
`timescale 1ns/1ps
module pcx_sync #(
   parameter int unsigned WIDTH  = 13,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pcx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcx_group.sv
`timescale 1ns/1ps
module pcx_group #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [WIDTH-1:0]  pin_sync_i,
   input  logic              mask_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              clr_i,
   output logic [WIDTH-1:0]  mask_o,
   output logic              hit_o,
   output logic              flag_o
);
   generate
      if (WIDTH == 0 || WIDTH > DATA_W) begin : g_bad
         $error("pcx_group: WIDTH must be in 1..DATA_W");
      end
   endgenerate

   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] last_q;
   logic [WIDTH-1:0] moved;
   logic             flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else if (mask_we_i) mask_q <= wdata_i[WIDTH-1:0];
   end

   // previous level tracks every pin regardless of mask, so unmasking a
   // steady pin sees no difference
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= '0;
      else last_q <= pin_sync_i;
   end

   assign moved = (pin_sync_i ^ last_q) & mask_q;
   assign hit_o = |moved;

   // set has priority over clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else if (hit_o) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign mask_o = mask_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/pcx_regs.sv
`timescale 1ns/1ps
module pcx_regs
   import pcx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NUM_GRP-1:0] flag_i,
   input  logic [DATA_W-1:0] mask0_i,
   input  logic [DATA_W-1:0] mask1_i,
   output logic [NUM_GRP-1:0] en_o,
   output logic [NUM_GRP-1:0] flag_wclr_o,
   output logic [DATA_W-1:0] rdata_o
);
   generate
      if (DATA_W < NUM_GRP) begin : g_bad
         $error("pcx_regs: DATA_W too small for group bits");
      end
   endgenerate

   logic [NUM_GRP-1:0] en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= '0;
      else if (wr_i && addr_i == RA_CTRL) en_q <= wdata_i[NUM_GRP-1:0];
   end

   assign flag_wclr_o = (wr_i && addr_i == RA_FLAG) ? wdata_i[NUM_GRP-1:0] : '0;
   assign en_o        = en_q;

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         RA_CTRL:  rdata_o[NUM_GRP-1:0] = en_q;
         RA_FLAG:  rdata_o[NUM_GRP-1:0] = flag_i;
         RA_MASK0: rdata_o = mask0_i;
         RA_MASK1: rdata_o = mask1_i;
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/pin_change_irq.sv
`timescale 1ns/1ps
module pin_change_irq
   import pcx_pkg::*;
#(
   parameter int unsigned G0_PINS     = 8,
   parameter int unsigned G1_PINS     = 5,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [G0_PINS+G1_PINS-1:0] pins_i,
   input  logic                       glob_ie_i,
   input  logic [NUM_GRP-1:0]         ack_i,
   input  logic                       reg_wr_i,
   input  logic [ADDR_W-1:0]          reg_addr_i,
   input  logic [DATA_W-1:0]          reg_wdata_i,
   output logic [DATA_W-1:0]          reg_rdata_o,
   output logic [NUM_GRP-1:0]         irq_o
);
   localparam int unsigned NPINS = G0_PINS + G1_PINS;

   logic [NPINS-1:0]   pin_sync;
   logic [NUM_GRP-1:0] grp_en;
   logic [NUM_GRP-1:0] grp_flag;
   logic [NUM_GRP-1:0] grp_hit;
   logic [NUM_GRP-1:0] grp_clr;
   logic [NUM_GRP-1:0] flag_wclr;
   logic [DATA_W-1:0]  mask_ext [NUM_GRP];

   pcx_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pins_i),
      .q_o   (pin_sync)
   );

   assign grp_clr = flag_wclr | ack_i;

   genvar g;
   generate
      for (g = 0; g < NUM_GRP; g++) begin : g_grp
         localparam int unsigned W  = (g == 0) ? G0_PINS : G1_PINS;
         localparam int unsigned LO = (g == 0) ? 0 : G0_PINS;
         localparam logic [ADDR_W-1:0] MADDR = (g == 0) ? RA_MASK0 : RA_MASK1;
         logic [W-1:0] mask;

         pcx_group #(.WIDTH(W), .DATA_W(DATA_W)) i_group (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .pin_sync_i(pin_sync[LO +: W]),
            .mask_we_i (reg_wr_i && reg_addr_i == MADDR),
            .wdata_i   (reg_wdata_i),
            .clr_i     (grp_clr[g]),
            .mask_o    (mask),
            .hit_o     (grp_hit[g]),
            .flag_o    (grp_flag[g])
         );

         always_comb begin
            mask_ext[g]        = '0;
            mask_ext[g][W-1:0] = mask;
         end
      end
   endgenerate

   pcx_regs #(.DATA_W(DATA_W)) i_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_wr_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .flag_i     (grp_flag),
      .mask0_i    (mask_ext[0]),
      .mask1_i    (mask_ext[1]),
      .en_o       (grp_en),
      .flag_wclr_o(flag_wclr),
      .rdata_o    (reg_rdata_o)
   );

   assign irq_o = grp_flag & grp_en & {NUM_GRP{glob_ie_i}};
endmodule

// File: rtl/pin_change_irq_chk.sv
`timescale 1ns/1ps
module pin_change_irq_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned G1_PINS = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              glob_ie_i,
   input logic [1:0]        irq_o,
   input logic [1:0]        reg_addr_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic [1:0]        grp_en,
   input logic [1:0]        grp_flag,
   input logic [1:0]        grp_hit,
   input logic [1:0]        grp_clr
);
   // R2
   reserved_low_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == 2'd0 || reg_addr_i == 2'd1) |-> (reg_rdata_o >> 2) == '0);

   // R2
   reserved_mask1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == 2'd3) |-> (reg_rdata_o >> G1_PINS) == '0);

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_chk
         // R8
         irq_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[g] |-> glob_ie_i);

         // R8
         irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[g] |-> grp_en[g]);

         // R7
         set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grp_hit[g] |=> grp_flag[g]);

         // R5
         clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (grp_clr[g] && !grp_hit[g]) |=> !grp_flag[g]);

         // R9
         flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(grp_flag[g]) |-> $past(grp_hit[g]));
      end
   endgenerate
endmodule

bind pin_change_irq pin_change_irq_chk #(.DATA_W(DATA_W), .G1_PINS(G1_PINS)) i_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .glob_ie_i  (glob_ie_i),
   .irq_o      (irq_o),
   .reg_addr_i (reg_addr_i),
   .reg_rdata_o(reg_rdata_o),
   .grp_en     (grp_en),
   .grp_flag   (grp_flag),
   .grp_hit    (grp_hit),
   .grp_clr    (grp_clr)
);

// File: tb/test_pin_change_irq.sv
`timescale 1ns/1ps
module test_pin_change_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] pins = '0;
   logic        gie = 1'b0;
   logic [1:0]  ack = '0;
   logic        wr = 1'b0;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [1:0]  irq;
   int          total = 0;
   int          bad = 0;

   always #2.5 clk = ~clk;

   pin_change_irq i_pin_change_irq (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .glob_ie_i(gie), .ack_i(ack),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   // {pins[12:0], expected flags[1:0]}; mask0=0xFF, mask1=0x0F (pin 12 masked)
   localparam logic [14:0] VEC [8] = '{
      {13'h0001, 2'b01},  // R3 rise pin0
      {13'h0001, 2'b00},  // R4 no change
      {13'h0000, 2'b01},  // R3 fall pin0
      {13'h0100, 2'b10},  // R3 pin8, R4 group isolation
      {13'h1100, 2'b00},  // R4 masked pin12
      {13'h0080, 2'b11},  // R3 both groups
      {13'h0880, 2'b10},  // R3 pin11
      {13'h1880, 2'b00}   // R4 masked pin12
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic setp(input logic [12:0] p);
      @(negedge clk); pins = p;
      repeat (4) @(negedge clk);
   endtask

   logic [7:0] rv;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rreg(a[1:0], rv); chk("R1 reset reg", rv, 0);
      end
      chk("R1 irq after reset", irq, 0);

      // R2 reserved bits
      wreg(2'd0, 8'hFF); rreg(2'd0, rv); chk("R2 ctrl reserved", rv, 8'h03);
      wreg(2'd3, 8'hFF); rreg(2'd3, rv); chk("R2 mask1 reserved", rv, 8'h1F);
      wreg(2'd2, 8'hA5); rreg(2'd2, rv); chk("R2 mask0 rw", rv, 8'hA5);

      // R4 masked change, R9 unmask steady pin
      wreg(2'd2, 8'h00);
      setp(13'h0008); rreg(2'd1, rv); chk("R4 masked pin3", rv, 0);
      wreg(2'd2, 8'h08); repeat (4) @(negedge clk);
      rreg(2'd1, rv); chk("R9 unmask steady", rv, 0);
      setp(13'h0000); rreg(2'd1, rv); chk("R3 fall pin3", rv, 8'h01);
      wreg(2'd1, 8'h03);

      // table
      wreg(2'd2, 8'hFF); wreg(2'd3, 8'h0F); wreg(2'd0, 8'h03);
      gie = 1'b1;
      for (int i = 0; i < 8; i++) begin
         setp(VEC[i][14:2]);
         rreg(2'd1, rv); chk("R3/R4 table flags", rv, {6'b0, VEC[i][1:0]});
         chk("R8 table irq", irq, VEC[i][1:0]);
         wreg(2'd1, 8'h03);
         rreg(2'd1, rv); chk("R5 table clear", rv, 0);
      end

      // R5 write-one-to-clear
      setp(13'h1881);
      wreg(2'd1, 8'h00); rreg(2'd1, rv); chk("R5 write zero keeps", rv, 8'h01);
      wreg(2'd1, 8'hFC); rreg(2'd1, rv); chk("R5 reserved write keeps", rv, 8'h01);
      wreg(2'd1, 8'h01); rreg(2'd1, rv); chk("R5 clear", rv, 0);

      // R6 acknowledge
      setp(13'h1981);
      @(negedge clk); ack = 2'b01; @(negedge clk); ack = 2'b00;
      rreg(2'd1, rv); chk("R6 other ack keeps", rv, 8'h02);
      @(negedge clk); ack = 2'b10; @(negedge clk); ack = 2'b00;
      rreg(2'd1, rv); chk("R6 ack clears", rv, 0);

      // R7 set wins over clear
      setp(13'h1983);
      @(negedge clk); pins = 13'h1981;
      @(negedge clk);
      @(negedge clk); ack = 2'b01;
      @(negedge clk); ack = 2'b00;
      rreg(2'd1, rv); chk("R7 set beats ack", rv, 8'h01);
      wreg(2'd1, 8'h03);
      @(negedge clk); pins = 13'h1983;
      @(negedge clk);
      @(negedge clk); wr = 1'b1; addr = 2'd1; wdata = 8'h01;
      @(negedge clk); wr = 1'b0;
      rreg(2'd1, rv); chk("R7 set beats write", rv, 8'h01);

      // R8 gating
      @(negedge clk); #1; chk("R8 all on", irq, 2'b01);
      gie = 1'b0; #1; chk("R8 gie off", irq, 2'b00);
      gie = 1'b1; wreg(2'd0, 8'h02); #1; chk("R8 en off", irq, 2'b00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule